// File: doc/BRIEF.md
# Multithread Fetch-to-Decode Dispatcher

This block sits between the per-thread instruction fetch queues and the decode stage of a multithreaded core. Every cycle it looks at the head entries of all thread queues and gathers up to a decode-width bundle of instructions into a single registered bundle that decode reads in the following cycle. For each queue it also raises a pop count in the same cycle, so that the queue drops the entries the bundle took.

The gathering walk starts at a thread chosen pseudo-randomly among the threads that are currently active. It moves through the active threads in circular order and keeps going round until the bundle is full or nothing is left to take. On each visit it takes at most one instruction from a thread. A thread that decode is stalling, that is inactive, or whose queue is empty gives nothing, and the walk moves past it. Each bundle slot carries the thread number it came from. An activity flag marks every cycle in which the bundle holds at least one instruction.

Top module: `fetch_decode_dispatch`

## Requirements
- R1: While `rst_n` is low, `bnd_cnt`, `bnd_vld`, `bnd_inst`, `bnd_tid` and `activity` are all zero.
- R2: A 16-bit shift register starts at `RND_SEED` and advances once per clock after reset. Its next value is the old value shifted left by one, with bit 0 set to bit15 xor bit13 xor bit12 xor bit10. In each cycle, its low 8 bits modulo the number of active threads give k. The walk starts at the k-th active thread, counting from 0 in ascending thread number.
- R3: Instructions fill the bundle from slot 0 upward with no gaps. The order is the order of the walk: visit the active threads in ascending circular order from the start thread, wrapping from the highest active thread back to the lowest, and repeat. `bnd_vld` bit k is set exactly for k < `bnd_cnt`. Unused slots read zero in `bnd_inst` and `bnd_tid`.
- R4: A thread with its `thr_stall` bit set, or with its `thr_active` bit clear, contributes nothing, and its pop count is zero.
- R5: On the n-th visit to a thread in a cycle (n from 0), the walk takes that thread's head entry n, and only when the thread's level exceeds n. A thread's pop count equals the number of its entries placed in the bundle, and the bundle tags each of them with that thread number.
- R6: The walk stops when the bundle holds `DEC_W` entries or no eligible entries remain. The count is the lesser of `DEC_W` and the sum of the levels of all eligible threads.
- R7: `activity` is high exactly in the cycles in which `bnd_cnt` is nonzero.
- R8: An all-zero `thr_active` produces no pops and an empty bundle.
- R9: A queue level above `DEC_W` behaves the same as a level of `DEC_W`.
- R10: Pop counts depend combinationally on the inputs of the current cycle. The bundle built from those inputs appears on the outputs after the next rising clock edge. Thread t's level is at `q_level[t*LVL_W +: LVL_W]`, its head entry s is at `q_head[(t*DEC_W+s)*INST_W +: INST_W]`, and bundle slot k is at `bnd_inst[k*INST_W +: INST_W]` and `bnd_tid[k*TID_W +: TID_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_active | input | NUM_THR | Active-thread mask |
| thr_stall | input | NUM_THR | Per-thread stall request from decode |
| q_level | input | NUM_THR*LVL_W | Per-thread count of valid head entries |
| q_head | input | NUM_THR*DEC_W*INST_W | First DEC_W entries of each thread queue |
| pop_cnt | output | NUM_THR*LVL_W | Entries taken from each queue this cycle |
| bnd_cnt | output | LVL_W | Number of valid bundle slots |
| bnd_vld | output | DEC_W | Per-slot valid bits |
| bnd_inst | output | DEC_W*INST_W | Bundle instruction slots |
| bnd_tid | output | DEC_W*TID_W | Thread number of each slot |
| activity | output | 1 | Bundle holds at least one instruction |

## Verification
The bench builds the block with three threads, a decode width of four and 16-bit instructions. With three threads, the modulo step divides by 1, 2 and 3, and the circular wrap crosses a thread count that is not a power of two. With the decode width above the thread count, one cycle can take several entries from the same thread, so the rule that the n-th visit takes entry n is exercised. Queue levels are driven up to 7, which covers the clipping of levels above the decode width. The reference model replays the shift-register sequence and performs the walk one visit at a time.

// File: rtl/fdd_pkg.sv
package fdd_pkg;

  localparam int RND_W = 16;

  // Left-shifting maximal-length sequence, taps 16,14,13,11.
  function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] s);
    return {s[RND_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/fdd_lfsr.sv
module fdd_lfsr
  import fdd_pkg::*;
#(
  parameter logic [RND_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  output logic [RND_W-1:0] state
);

  logic [RND_W-1:0] st_q;
  logic [RND_W-1:0] st_d;

  always_comb begin
    st_d = st_q;
    if (adv_en) st_d = rnd_step(st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED;
    else        st_q <= st_d;
  end

  assign state = st_q;

  // R2: sequence never collapses to the all-zero lock state
  a_r2_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);

  // R2: every enabled cycle moves the sequence on
  a_r2_state_moves: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en |=> st_q != $past(st_q));

endmodule

// File: rtl/fdd_start_pick.sv
module fdd_start_pick #(
  parameter int NUM_THR = 4,
  parameter int TID_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_THR-1:0] act,
  input  logic [7:0]         rnd,
  output logic [TID_W-1:0]   start_tid
);

  localparam int NA_W = $clog2(NUM_THR + 1);

  logic [NA_W-1:0]  n_act;
  logic [NA_W-1:0]  pick_idx;
  logic [NA_W-1:0]  seen;
  logic [TID_W-1:0] sel;

  always_comb begin
    n_act = '0;
    for (int t = 0; t < NUM_THR; t++) n_act = n_act + NA_W'(act[t]);
  end

  always_comb begin
    pick_idx = '0;
    if (n_act != '0) pick_idx = NA_W'(int'(rnd) % int'(n_act));
  end

  always_comb begin
    seen = '0;
    sel  = '0;
    for (int t = 0; t < NUM_THR; t++) begin
      if (act[t]) begin
        if (seen == pick_idx) sel = TID_W'(t);
        seen = seen + NA_W'(1);
      end
    end
  end

  assign start_tid = sel;

  // R2: the chosen start is always an active thread
  a_r2_start_active: assert property (@(posedge clk) disable iff (!rst_n)
    (|act) |-> act[start_tid]);

endmodule

// File: rtl/fdd_packer.sv
module fdd_packer #(
  parameter int NUM_THR = 4,
  parameter int DEC_W   = 4,
  parameter int INST_W  = 32,
  parameter int TID_W   = 2,
  parameter int LVL_W   = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_THR-1:0]                act,
  input  logic [NUM_THR-1:0]                stall,
  input  logic [NUM_THR*LVL_W-1:0]          lvl_flat,
  input  logic [NUM_THR*DEC_W*INST_W-1:0]   head_flat,
  input  logic [TID_W-1:0]                  start_tid,
  output logic [DEC_W*INST_W-1:0]           slot_inst,
  output logic [DEC_W*TID_W-1:0]            slot_tid,
  output logic [DEC_W-1:0]                  slot_vld,
  output logic [LVL_W-1:0]                  take_cnt,
  output logic [NUM_THR*LVL_W-1:0]          pop_flat
);

  logic [LVL_W-1:0]  lvl_raw [NUM_THR];
  logic [LVL_W-1:0]  lvl_c   [NUM_THR];
  logic [INST_W-1:0] hd      [NUM_THR][DEC_W];
  logic [INST_W-1:0] s_inst  [DEC_W];
  logic [TID_W-1:0]  s_tid   [DEC_W];
  logic [DEC_W-1:0]  s_vld;
  logic [LVL_W-1:0]  pop     [NUM_THR];
  logic [LVL_W-1:0]  n_take;
  logic [NUM_THR-1:0] elig;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_unpack
    assign lvl_raw[t] = lvl_flat[t*LVL_W +: LVL_W];
    assign elig[t]    = act[t] & ~stall[t];
    for (genvar s = 0; s < DEC_W; s++) begin : g_slot
      assign hd[t][s] = head_flat[(t*DEC_W+s)*INST_W +: INST_W];
    end
  end

  // Levels above the decode width cannot add anything this cycle.
  always_comb begin
    for (int t = 0; t < NUM_THR; t++) begin
      lvl_c[t] = lvl_raw[t];
      if (lvl_raw[t] > LVL_W'(DEC_W)) lvl_c[t] = LVL_W'(DEC_W);
    end
  end

  // Round r visits every thread once, in circular order from start_tid;
  // a thread still holding more than r entries gives its entry r.
  always_comb begin
    int tt;
    n_take = '0;
    s_vld  = '0;
    for (int k = 0; k < DEC_W; k++) begin
      s_inst[k] = '0;
      s_tid[k]  = '0;
    end
    for (int t = 0; t < NUM_THR; t++) pop[t] = '0;
    for (int r = 0; r < DEC_W; r++) begin
      for (int p = 0; p < NUM_THR; p++) begin
        tt = int'(start_tid) + p;
        if (tt >= NUM_THR) tt = tt - NUM_THR;
        if (elig[tt] && (lvl_c[tt] > LVL_W'(r)) && (n_take < LVL_W'(DEC_W))) begin
          s_inst[n_take] = hd[tt][r];
          s_tid[n_take]  = TID_W'(tt);
          s_vld[n_take]  = 1'b1;
          pop[tt]        = pop[tt] + LVL_W'(1);
          n_take         = n_take + LVL_W'(1);
        end
      end
    end
  end

  for (genvar k = 0; k < DEC_W; k++) begin : g_out
    assign slot_inst[k*INST_W +: INST_W] = s_inst[k];
    assign slot_tid[k*TID_W +: TID_W]    = s_tid[k];
  end

  for (genvar t = 0; t < NUM_THR; t++) begin : g_pop
    assign pop_flat[t*LVL_W +: LVL_W] = pop[t];

    // R4: blocked or inactive threads are never popped
    a_r4_blocked_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (!act[t] || stall[t]) |-> pop_flat[t*LVL_W +: LVL_W] == '0);

    // R5: no thread gives more than it holds
    a_r5_pop_within_level: assert property (@(posedge clk) disable iff (!rst_n)
      pop_flat[t*LVL_W +: LVL_W] <= lvl_c[t]);
  end

  assign slot_vld = s_vld;
  assign take_cnt = n_take;

  // R6: the bundle never exceeds the decode width
  a_r6_take_cap: assert property (@(posedge clk) disable iff (!rst_n)
    take_cnt <= LVL_W'(DEC_W));

endmodule

// File: rtl/fetch_decode_dispatch.sv
module fetch_decode_dispatch
  import fdd_pkg::*;
#(
  parameter int               NUM_THR  = 4,
  parameter int               DEC_W    = 4,
  parameter int               INST_W   = 32,
  parameter logic [RND_W-1:0] RND_SEED = 16'hACE1,
  localparam int              TID_W    = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
  localparam int              LVL_W    = $clog2(DEC_W + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_THR-1:0]              thr_active,
  input  logic [NUM_THR-1:0]              thr_stall,
  input  logic [NUM_THR*LVL_W-1:0]        q_level,
  input  logic [NUM_THR*DEC_W*INST_W-1:0] q_head,
  output logic [NUM_THR*LVL_W-1:0]        pop_cnt,
  output logic [LVL_W-1:0]                bnd_cnt,
  output logic [DEC_W-1:0]                bnd_vld,
  output logic [DEC_W*INST_W-1:0]         bnd_inst,
  output logic [DEC_W*TID_W-1:0]          bnd_tid,
  output logic                            activity
);

  localparam int SUM_W = $clog2(NUM_THR * DEC_W + 1);

  logic [RND_W-1:0]        rnd_state;
  logic [TID_W-1:0]        start_tid;
  logic [DEC_W*INST_W-1:0] pk_inst;
  logic [DEC_W*TID_W-1:0]  pk_tid;
  logic [DEC_W-1:0]        pk_vld;
  logic [LVL_W-1:0]        pk_cnt;
  logic                    rnd_en;
  logic                    upd_en;

  assign rnd_en = 1'b1;
  assign upd_en = 1'b1;

  fdd_lfsr #(.SEED(RND_SEED)) u_rnd (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_en (rnd_en),
    .state  (rnd_state)
  );

  fdd_start_pick #(.NUM_THR(NUM_THR), .TID_W(TID_W)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (thr_active),
    .rnd       (rnd_state[7:0]),
    .start_tid (start_tid)
  );

  fdd_packer #(
    .NUM_THR (NUM_THR),
    .DEC_W   (DEC_W),
    .INST_W  (INST_W),
    .TID_W   (TID_W),
    .LVL_W   (LVL_W)
  ) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (thr_active),
    .stall     (thr_stall),
    .lvl_flat  (q_level),
    .head_flat (q_head),
    .start_tid (start_tid),
    .slot_inst (pk_inst),
    .slot_tid  (pk_tid),
    .slot_vld  (pk_vld),
    .take_cnt  (pk_cnt),
    .pop_flat  (pop_cnt)
  );

  // Bundle register: next-state and storage kept apart.
  logic [LVL_W-1:0]        cnt_d,  cnt_q;
  logic [DEC_W-1:0]        vld_d,  vld_q;
  logic [DEC_W*INST_W-1:0] inst_d, inst_q;
  logic [DEC_W*TID_W-1:0]  tid_d,  tid_q;
  logic                    act_d,  act_q;

  always_comb begin
    cnt_d  = cnt_q;
    vld_d  = vld_q;
    inst_d = inst_q;
    tid_d  = tid_q;
    act_d  = act_q;
    if (upd_en) begin
      cnt_d  = pk_cnt;
      vld_d  = pk_vld;
      inst_d = pk_inst;
      tid_d  = pk_tid;
      act_d  = |pk_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      vld_q  <= '0;
      inst_q <= '0;
      tid_q  <= '0;
      act_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      vld_q  <= vld_d;
      inst_q <= inst_d;
      tid_q  <= tid_d;
      act_q  <= act_d;
    end
  end

  assign bnd_cnt  = cnt_q;
  assign bnd_vld  = vld_q;
  assign bnd_inst = inst_q;
  assign bnd_tid  = tid_q;
  assign activity = act_q;

  logic [SUM_W-1:0] pop_sum;
  always_comb begin
    pop_sum = '0;
    for (int t = 0; t < NUM_THR; t++)
      pop_sum = pop_sum + SUM_W'(pop_cnt[t*LVL_W +: LVL_W]);
  end

  // R6/R10: the registered count equals the entries popped a cycle earlier
  a_r6_cnt_matches_pops: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> SUM_W'(bnd_cnt) == $past(pop_sum));

  // R8: no active threads leaves the next bundle empty
  a_r8_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_active == '0) |=> (bnd_cnt == '0) && !activity);

  // R7: activity tracks a non-empty bundle
  a_r7_activity_flag: assert property (@(posedge clk) disable iff (!rst_n)
    activity == (bnd_cnt != '0));

  // R3: valid slots are packed from slot 0 and agree with the count
  a_r3_slots_packed: assert property (@(posedge clk) disable iff (!rst_n)
    ((bnd_vld & (bnd_vld + DEC_W'(1))) == '0) &&
    ($countones(bnd_vld) == int'(bnd_cnt)));

endmodule

// File: tb/tb_fetch_decode_dispatch.sv
`timescale 1ns/1ps
module tb_fetch_decode_dispatch;

  localparam int NT = 3;
  localparam int DW = 4;
  localparam int IW = 16;
  localparam int LW = 3;
  localparam int TW = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NT-1:0]     thr_active;
  logic [NT-1:0]     thr_stall;
  logic [NT*LW-1:0]  q_level;
  logic [NT*DW*IW-1:0] q_head;
  logic [NT*LW-1:0]  pop_cnt;
  logic [LW-1:0]     bnd_cnt;
  logic [DW-1:0]     bnd_vld;
  logic [DW*IW-1:0]  bnd_inst;
  logic [DW*TW-1:0]  bnd_tid;
  logic              activity;

  fetch_decode_dispatch #(.NUM_THR(NT), .DEC_W(DW), .INST_W(IW), .RND_SEED(16'hACE1)) dut (
    .clk(clk), .rst_n(rst_n), .thr_active(thr_active), .thr_stall(thr_stall),
    .q_level(q_level), .q_head(q_head), .pop_cnt(pop_cnt), .bnd_cnt(bnd_cnt),
    .bnd_vld(bnd_vld), .bnd_inst(bnd_inst), .bnd_tid(bnd_tid), .activity(activity)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench-side stimulus and model state
  bit          m_act[NT];
  bit          m_stl[NT];
  int          m_lvl[NT];
  int          m_hd[NT][DW];
  logic [15:0] m_rnd;
  int          e_cnt;
  int          e_inst[DW];
  int          e_tid[DW];
  int          e_pop[NT];
  string       ph;

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", ph, what, act, exp);
    end
  endtask

  task automatic drive();
    for (int t = 0; t < NT; t++) begin
      thr_active[t] = m_act[t];
      thr_stall[t]  = m_stl[t];
      q_level[t*LW +: LW] = LW'(m_lvl[t]);
      for (int s = 0; s < DW; s++) q_head[(t*DW+s)*IW +: IW] = IW'(m_hd[t][s]);
    end
  endtask

  // Walk one visit at a time over the active threads.
  task automatic model();
    int n_act, k, st, avail, t, seen;
    int took[NT];
    int lim[NT];
    e_cnt = 0;
    for (int i = 0; i < DW; i++) begin e_inst[i] = 0; e_tid[i] = 0; end
    for (int i = 0; i < NT; i++) begin e_pop[i] = 0; took[i] = 0; end
    n_act = 0;
    for (int i = 0; i < NT; i++) if (m_act[i]) n_act++;
    if (n_act == 0) return;
    k = int'(m_rnd[7:0]) % n_act;
    seen = 0; st = 0;
    for (int i = 0; i < NT; i++) if (m_act[i]) begin
      if (seen == k) st = i;
      seen++;
    end
    avail = 0;
    for (int i = 0; i < NT; i++) begin
      lim[i] = (m_lvl[i] > DW) ? DW : m_lvl[i];
      if (m_act[i] && !m_stl[i]) avail += lim[i];
    end
    t = st;
    while (avail > 0 && e_cnt < DW) begin
      if (m_act[t] && !m_stl[t] && took[t] < lim[t]) begin
        e_inst[e_cnt] = m_hd[t][took[t]];
        e_tid[e_cnt]  = t;
        took[t]++;
        e_cnt++;
        avail--;
      end
      do t = (t + 1) % NT; while (!m_act[t]);
    end
    for (int i = 0; i < NT; i++) e_pop[i] = took[i];
  endtask

  // Called at a negedge with inputs in place; returns at the next negedge.
  task automatic step();
    drive();
    #1;
    model();
    for (int t = 0; t < NT; t++) chk($sformatf("pop[%0d]", t), int'(pop_cnt[t*LW +: LW]), e_pop[t]);
    @(posedge clk);
    m_rnd = {m_rnd[14:0], m_rnd[15] ^ m_rnd[13] ^ m_rnd[12] ^ m_rnd[10]};
    @(negedge clk);
    chk("cnt", int'(bnd_cnt), e_cnt);
    chk("activity", int'(activity), int'(e_cnt != 0));
    for (int k = 0; k < DW; k++) begin
      chk($sformatf("vld[%0d]", k), int'(bnd_vld[k]), int'(k < e_cnt));
      chk($sformatf("inst[%0d]", k), int'(bnd_inst[k*IW +: IW]), e_inst[k]);
      chk($sformatf("tid[%0d]", k), int'(bnd_tid[k*TW +: TW]), e_tid[k]);
    end
  endtask

  task automatic fill_heads();
    for (int t = 0; t < NT; t++)
      for (int s = 0; s < DW; s++) m_hd[t][s] = int'($urandom_range(1, 65535));
  endtask

  initial begin
    rst_n = 1'b0;
    for (int t = 0; t < NT; t++) begin m_act[t] = 1; m_stl[t] = 0; m_lvl[t] = 4; end
    fill_heads();
    drive();
    repeat (3) @(negedge clk);
    ph = "R1 reset";
    chk("cnt", int'(bnd_cnt), 0);
    chk("vld", int'(bnd_vld), 0);
    chk("inst", int'(bnd_inst != '0), 0);
    chk("tid", int'(bnd_tid != '0), 0);
    chk("activity", int'(activity), 0);
    rst_n = 1'b1;
    m_rnd = 16'hACE1;

    ph = "R8 zero mask";
    for (int c = 0; c < 3; c++) begin
      for (int t = 0; t < NT; t++) begin m_act[t] = 0; m_lvl[t] = 4; end
      fill_heads();
      step();
    end

    ph = "R4 stall";
    for (int c = 0; c < 4; c++) begin
      for (int t = 0; t < NT; t++) begin
        m_act[t] = 1; m_lvl[t] = 3;
        m_stl[t] = (c < 2) ? 1 : (t != 1);
      end
      fill_heads();
      step();
    end

    ph = "R9 R5 clip single thread";
    for (int c = 0; c < 3; c++) begin
      for (int t = 0; t < NT; t++) begin m_act[t] = (t == c); m_stl[t] = 0; m_lvl[t] = 7; end
      fill_heads();
      step();
    end

    ph = "R6 short supply";
    for (int c = 0; c < 4; c++) begin
      for (int t = 0; t < NT; t++) begin m_act[t] = 1; m_stl[t] = 0; m_lvl[t] = (t == 1) ? 0 : 1; end
      fill_heads();
      step();
    end

    ph = "R2 R3 R5 R6 R7 R10 random";
    for (int c = 0; c < 400; c++) begin
      for (int t = 0; t < NT; t++) begin
        m_act[t] = ($urandom_range(0, 3) != 0);
        m_stl[t] = ($urandom_range(0, 3) == 0);
        m_lvl[t] = int'($urandom_range(0, 7));
      end
      fill_heads();
      step();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule